// File: doc/BRIEF.md
# Serial Avionics Word Transmitter with Eight-Word Queue

This block takes 31-bit avionics data words from a 16-bit host bus and sends them as a return-to-zero serial stream. The host writes each word as two halves with two strobes, the label half first and the upper data half second. The second strobe places the assembled word in an eight-entry queue. When the host raises the send enable, the transmitter takes queued words in order. It appends a parity bit and drives two digital controls, one for each side of an external line driver.

The timing is fixed in master-clock cycles. The fast rate uses a divide-by-10 data clock, and the slow rate uses a divide-by-80 data clock. Every bit is a driven half followed by a null half. Consecutive words are separated by a gap of four data clocks. A ready flag tells the host that nothing is queued or in flight. A loopback port copies the serial stream for a local receiver in true form and for a second local receiver in complemented form.

Top module: `a429_tx_top`

## Requirements
- R1: A word is committed to the queue only by a second-half strobe (`ld_hi`) that follows a first-half strobe (`ld_lo`). A second-half strobe with no first-half strobe held since the last commit is ignored.
- R2: The queue holds at most eight words. A commit while eight words are queued is discarded, and that word is never transmitted.
- R3: `ready` is high after reset. It is low while any word is queued or being sent, including the gap after a word. It returns high once the queue is empty and the last gap has ended.
- R4: Serial bit 32 is a parity bit over the 31 data bits. With `par_even` at 0 the 32 bits hold an odd number of ones, and with `par_even` at 1 they hold an even number.
- R5: A one drives `line_hi`=1 and `line_lo`=0. A zero drives `line_hi`=0 and `line_lo`=1. Null drives both to 0. Word bit 1 is sent first and the parity bit last.
- R6: With `slow_sel`=0, each bit is driven for 5 clocks and then null for 5 clocks. The next word starts 45 clocks after the last bit's driven half ends (5 null plus a 40-clock gap).
- R7: With `slow_sel`=1, each bit is driven for 40 clocks and then null for 40 clocks. The next word starts 360 clocks after the last bit's driven half ends.
- R8: When the transmitter is idle and the queue is non-empty, bit 1 is on the line in the clock after `tx_en` is sampled high.
- R9: If `tx_en` drops during a word, that word completes, and no further word starts until `tx_en` is high again.
- R10: With `st_en`=1, `loop1_hi`/`loop1_lo` equal `line_hi`/`line_lo`, and `loop2_hi`/`loop2_lo` equal `line_lo`/`line_hi`. With `st_en`=0, all four loop outputs are 0.
- R11: First half bit layout: data bits 7:0 carry word bits 1..8, with bit 7 holding word bit 1. Data bits 15:11 carry word bits 13..9. Bit 10 carries word bit 31, and bit 9 carries word bit 30. Bit 8 is ignored. Second half layout: data bits 15:0 carry word bits 29..14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_data | input | 16 | Host data for either word half |
| ld_lo | input | 1 | First-half strobe, one cycle |
| ld_hi | input | 1 | Second-half strobe, one cycle; commits the word |
| tx_en | input | 1 | Send enable |
| slow_sel | input | 1 | 0: divide by 10, 1: divide by 80 |
| par_even | input | 1 | 0: odd parity, 1: even parity |
| st_en | input | 1 | Enables the loopback outputs |
| ready | output | 1 | Queue empty and transmitter idle |
| line_hi | output | 1 | A-side driver control |
| line_lo | output | 1 | B-side driver control |
| loop1_hi | output | 1 | Loopback, true stream, one level |
| loop1_lo | output | 1 | Loopback, true stream, zero level |
| loop2_hi | output | 1 | Loopback, complemented stream, one level |
| loop2_lo | output | 1 | Loopback, complemented stream, zero level |

## Verification
The serial decoder in the bench is fed several word patterns, each chosen to separate a different fault.
- Words with asymmetric bit patterns across both halves show whether the half layout is mapped wrongly or the bits are sent in reverse order.
- Odd and even parity settings applied to words with different one counts show whether the parity sense is inverted.
- Back-to-back words at both rates measure the null and gap lengths, which exposes errors in the divider or the gap counter.
- Overfilling the queue with nine distinct words, and dropping the enable mid-word, separate a correct drop-and-hold policy from one that overwrites entries or cuts a word short.

// File: rtl/a429_tx_pkg.sv
// Shared types and helpers for the serial word transmitter.
// Assumes a 31-bit data word and a 32nd parity position.
package a429_tx_pkg;

    localparam int WORD_W = 31;

    typedef enum logic [1:0] {
        SER_IDLE,
        SER_DATA,
        SER_NULL,
        SER_GAP
    } ser_state_t;

    // Parity bit: odd total ones when even_sel=0, even total when 1.
    function automatic logic parity_bit(input logic [WORD_W-1:0] w, input logic even_sel);
        return even_sel ? (^w) : ~(^w);
    endfunction

endpackage

// File: rtl/a429_tx_loader.sv
// Assembles a 31-bit word from two host strobes.
// Assumes strobes are single-cycle pulses and never coincide.
// The second strobe is accepted only while a first half is held.
module a429_tx_loader
    import a429_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       bus_i,
    input  logic              ld_first_i,
    input  logic              ld_second_i,
    output logic              commit_o,
    output logic [WORD_W-1:0] word_o
);
    logic [7:0]        hold_lbl;
    logic [6:0]        hold_up;
    logic              armed;
    logic [WORD_W-1:0] asm_word;
    logic              par_slot_unused;

    assign par_slot_unused = bus_i[8];

    // Map the held first half and the live second half onto word bit order.
    always_comb begin
        asm_word = '0;
        for (int k = 0; k < 8; k++) asm_word[k] = hold_lbl[7-k];
        for (int j = 0; j < 5; j++) asm_word[8+j] = hold_up[2+j];
        asm_word[28:13] = bus_i;
        asm_word[29]    = hold_up[0];
        asm_word[30]    = hold_up[1];
    end

    // Hold the first half and issue a one-cycle commit on a valid second half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_lbl <= '0;
            hold_up  <= '0;
            armed    <= 1'b0;
            commit_o <= 1'b0;
            word_o   <= '0;
        end else begin
            commit_o <= 1'b0;
            if (ld_first_i) begin
                hold_lbl <= bus_i[7:0];
                hold_up  <= bus_i[15:9];
                armed    <= 1'b1;
            end else if (ld_second_i && armed) begin
                word_o   <= asm_word;
                commit_o <= 1'b1;
                armed    <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/a429_tx_fifo.sv
// Word queue with drop-on-full writes and a combinational head output.
// Assumes pop is asserted only when the consumer wants the head word.
module a429_tx_fifo #(
    parameter int W     = 31,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic [W-1:0]               din_i,
    input  logic                       pop_i,
    output logic [W-1:0]               head_o,
    output logic                       empty_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          acc_push, acc_pop;

    assign empty_o  = (count == '0);
    assign acc_push = push_i && (count != CW'(DEPTH));
    assign acc_pop  = pop_i && !empty_o;
    assign head_o   = mem[rd_ptr];
    assign count_o  = count;

    // Store an accepted word at the write pointer.
    always_ff @(posedge clk) begin
        if (acc_push) mem[wr_ptr] <= din_i;
    end

    // Advance pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (acc_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (acc_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            if (acc_push && !acc_pop)      count <= count + 1'b1;
            else if (!acc_push && acc_pop) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/a429_tx_serializer.sv
// Sends 32 return-to-zero bits per word, least word bit first, then a gap.
// Assumes slow_sel is not changed while a word is in flight.
// Once a word starts it always runs to the end of its gap.
module a429_tx_serializer
    import a429_tx_pkg::*;
#(
    parameter int HS_DIV   = 10,
    parameter int LS_DIV   = 80,
    parameter int GAP_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en_i,
    input  logic              slow_i,
    input  logic              par_even_i,
    input  logic              empty_i,
    input  logic [WORD_W-1:0] head_i,
    output logic              pop_o,
    output logic              idle_o,
    output logic              hi_o,
    output logic              lo_o
);
    localparam int NBITS = WORD_W + 1;
    localparam int IW    = $clog2(NBITS);
    localparam int CW    = $clog2(GAP_BITS * LS_DIV + 1);

    ser_state_t      st;
    logic [CW-1:0]   cnt;
    logic [IW-1:0]   idx;
    logic [NBITS-1:0] sh;
    logic [CW-1:0]   half_last, gap_last;

    assign half_last = slow_i ? CW'(LS_DIV/2 - 1) : CW'(HS_DIV/2 - 1);
    assign gap_last  = slow_i ? CW'(GAP_BITS*LS_DIV - 1) : CW'(GAP_BITS*HS_DIV - 1);

    // Take the next word when idle or at the end of a gap.
    assign pop_o  = tx_en_i && !empty_i &&
                    ((st == SER_IDLE) || ((st == SER_GAP) && (cnt == gap_last)));
    assign idle_o = (st == SER_IDLE);
    assign hi_o   = (st == SER_DATA) && sh[0];
    assign lo_o   = (st == SER_DATA) && !sh[0];

    // Sequence driven halves, null halves and the word gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= SER_IDLE;
            cnt <= '0;
            idx <= '0;
            sh  <= '0;
        end else begin
            case (st)
                SER_IDLE: begin
                    if (pop_o) begin
                        st  <= SER_DATA;
                        cnt <= '0;
                        idx <= '0;
                        sh  <= {parity_bit(head_i, par_even_i), head_i};
                    end
                end
                SER_DATA: begin
                    if (cnt == half_last) begin
                        st  <= SER_NULL;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SER_NULL: begin
                    if (cnt == half_last) begin
                        cnt <= '0;
                        if (idx == IW'(NBITS-1)) begin
                            st <= SER_GAP;
                        end else begin
                            idx <= idx + 1'b1;
                            sh  <= sh >> 1;
                            st  <= SER_DATA;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (cnt == gap_last) begin
                        cnt <= '0;
                        if (pop_o) begin
                            st  <= SER_DATA;
                            idx <= '0;
                            sh  <= {parity_bit(head_i, par_even_i), head_i};
                        end else begin
                            st <= SER_IDLE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/a429_tx_top.sv
// Transmitter top: host loader, word queue, serializer and loopback.
// Assumes a single clock domain and a synchronous active-low reset.
module a429_tx_top #(
    parameter int DEPTH    = 8,
    parameter int HS_DIV   = 10,
    parameter int LS_DIV   = 80,
    parameter int GAP_BITS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] bus_data,
    input  logic        ld_lo,
    input  logic        ld_hi,
    input  logic        tx_en,
    input  logic        slow_sel,
    input  logic        par_even,
    input  logic        st_en,
    output logic        ready,
    output logic        line_hi,
    output logic        line_lo,
    output logic        loop1_hi,
    output logic        loop1_lo,
    output logic        loop2_hi,
    output logic        loop2_lo
);
    import a429_tx_pkg::*;

    logic                       commit;
    logic [WORD_W-1:0]          new_word;
    logic [WORD_W-1:0]          head;
    logic                       empty, deq, ser_idle;
    logic [$clog2(DEPTH+1)-1:0] fifo_cnt;

    a429_tx_loader u_loader (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_i       (bus_data),
        .ld_first_i  (ld_lo),
        .ld_second_i (ld_hi),
        .commit_o    (commit),
        .word_o      (new_word)
    );

    a429_tx_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (commit),
        .din_i   (new_word),
        .pop_i   (deq),
        .head_o  (head),
        .empty_o (empty),
        .count_o (fifo_cnt)
    );

    a429_tx_serializer #(.HS_DIV(HS_DIV), .LS_DIV(LS_DIV), .GAP_BITS(GAP_BITS)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en_i    (tx_en),
        .slow_i     (slow_sel),
        .par_even_i (par_even),
        .empty_i    (empty),
        .head_i     (head),
        .pop_o      (deq),
        .idle_o     (ser_idle),
        .hi_o       (line_hi),
        .lo_o       (line_lo)
    );

    // Ready only when nothing is queued and nothing is in flight.
    assign ready    = empty && ser_idle;
    // Loopback: true pair to the first receiver, swapped pair to the second.
    assign loop1_hi = st_en && line_hi;
    assign loop1_lo = st_en && line_lo;
    assign loop2_hi = st_en && line_lo;
    assign loop2_lo = st_en && line_hi;
endmodule

// File: rtl/a429_tx_chk.sv
// Protocol checker bound to the transmitter top.
// Assumes the bound signals are sampled at the top's clock.
module a429_tx_chk #(
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       line_hi,
    input logic                       line_lo,
    input logic                       ready,
    input logic                       pop,
    input logic [$clog2(DEPTH+1)-1:0] fifo_cnt
);
    AST_DRIVE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_hi && line_lo)); // R5
    AST_RZ_AFTER_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_hi) |-> !line_lo); // R5
    AST_RZ_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_lo) |-> !line_hi); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= ($clog2(DEPTH+1))'(DEPTH)); // R2
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt == ($clog2(DEPTH+1))'(DEPTH) && !pop) |=> fifo_cnt == ($clog2(DEPTH+1))'(DEPTH)); // R2
    AST_READY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (fifo_cnt == '0)); // R3
    AST_IDLE_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !(line_hi || line_lo)); // R3
endmodule

bind a429_tx_top a429_tx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_hi  (line_hi),
    .line_lo  (line_lo),
    .ready    (ready),
    .pop      (deq),
    .fifo_cnt (fifo_cnt)
);

// File: tb/tb_a429_tx_top.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_a429_tx_top;
    localparam int CAP = 1200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_data = '0;
    logic        ld_lo = 1'b0, ld_hi = 1'b0, tx_en = 1'b0;
    logic        slow_sel = 1'b0, par_even = 1'b0, st_en = 1'b0;
    logic        ready, line_hi, line_lo, loop1_hi, loop1_lo, loop2_hi, loop2_lo;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    a429_tx_top dut (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .ld_lo(ld_lo), .ld_hi(ld_hi),
        .tx_en(tx_en), .slow_sel(slow_sel), .par_even(par_even), .st_en(st_en),
        .ready(ready), .line_hi(line_hi), .line_lo(line_lo),
        .loop1_hi(loop1_hi), .loop1_lo(loop1_lo), .loop2_hi(loop2_hi), .loop2_lo(loop2_lo)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] framed(input logic [30:0] w, input logic even);
        logic p;
        p = even ? (^w) : ~(^w);
        return {p, w};
    endfunction

    // Host layout from R11; bit 8 of the first half is set to show it is ignored.
    function automatic logic [15:0] half1(input logic [30:0] w);
        logic [15:0] b;
        for (int k = 0; k < 8; k++) b[7-k] = w[k];
        b[8]     = 1'b1;
        b[9]     = w[29];
        b[10]    = w[30];
        b[15:11] = w[12:8];
        return b;
    endfunction

    task automatic load_word(input logic [30:0] w);
        @(negedge clk); bus_data = half1(w); ld_lo = 1'b1;
        @(negedge clk); ld_lo = 1'b0; bus_data = w[28:13]; ld_hi = 1'b1;
        @(negedge clk); ld_hi = 1'b0; bus_data = '0;
        @(negedge clk);
    endtask

    // Decode one word from the line, measuring every half-bit length.
    task automatic recv(input int half, output logic [31:0] w, output bit ok, output int tail);
        int n, z, wn;
        logic v;
        ok = 1'b1; w = '0; tail = 0; wn = 0;
        while (!(line_hi || line_lo) && wn < CAP) begin @(negedge clk); wn++; end
        if (wn >= CAP) begin ok = 1'b0; tail = CAP; return; end
        for (int b = 0; b < 32; b++) begin
            v = line_hi; n = 0;
            while (line_hi || line_lo) begin
                if (line_hi !== v || line_lo !== !v) ok = 1'b0;
                n++; @(negedge clk);
            end
            if (n != half) ok = 1'b0;
            w[b] = v; z = 0;
            while (!line_hi && !line_lo && z < CAP) begin z++; @(negedge clk); end
            if (b < 31 && z != half) ok = 1'b0;
            if (b == 31) tail = z;
        end
    endtask

    task automatic t_reset;
        check(ready === 1'b1, "R3 ready after reset", ready, 1);
        check({line_hi, line_lo} === 2'b00, "R5 null after reset", {line_hi, line_lo}, 0);
        check({loop1_hi, loop1_lo, loop2_hi, loop2_lo} === 4'b0, "R10 loop quiet after reset",
              {loop1_hi, loop1_lo, loop2_hi, loop2_lo}, 0);
    endtask

    task automatic t_single_fast;
        logic [30:0] w = 31'h2A5C_3E91;
        logic [31:0] got; bit ok; int tail;
        par_even = 1'b0; slow_sel = 1'b0;
        load_word(w);
        check(ready === 1'b0, "R3 ready low once loaded", ready, 0);
        tx_en = 1'b1;
        @(negedge clk);
        check(line_hi || line_lo, "R8 first bit one clock after enable", {line_hi, line_lo}, 1);
        recv(5, got, ok, tail);
        tx_en = 1'b0;
        check(got === framed(w, 1'b0), "R1 R11 R4 R5 word and odd parity", got, framed(w, 1'b0));
        check(ok, "R6 fast half-bit lengths", ok, 1);
        check(ready === 1'b1, "R3 ready after drain", ready, 1);
    endtask

    task automatic t_even_parity;
        logic [30:0] w = 31'h0000_0007;
        logic [31:0] got; bit ok; int tail;
        par_even = 1'b1;
        load_word(w);
        tx_en = 1'b1;
        recv(5, got, ok, tail);
        tx_en = 1'b0;
        check(got === framed(w, 1'b1), "R4 even parity", got, framed(w, 1'b1));
        par_even = 1'b0;
    endtask

    task automatic t_two_fast;
        logic [30:0] a = 31'h7FFF_0001, b = 31'h0123_4567;
        logic [31:0] g1, g2; bit ok1, ok2; int t1, t2;
        load_word(a); load_word(b);
        tx_en = 1'b1;
        recv(5, g1, ok1, t1);
        recv(5, g2, ok2, t2);
        tx_en = 1'b0;
        check(t1 == 45, "R6 fast null plus gap", t1, 45);
        check(g1 === framed(a, 1'b0) && g2 === framed(b, 1'b0), "R5 two words in order", g2, framed(b, 1'b0));
    endtask

    task automatic t_two_slow;
        logic [30:0] a = 31'h5555_AAAA, b = 31'h1F0F_70F0;
        logic [31:0] g1, g2; bit ok1, ok2; int t1, t2;
        slow_sel = 1'b1;
        load_word(a); load_word(b);
        tx_en = 1'b1;
        recv(40, g1, ok1, t1);
        recv(40, g2, ok2, t2);
        tx_en = 1'b0;
        check(ok1 && ok2, "R7 slow half-bit lengths", {ok1, ok2}, 3);
        check(t1 == 360, "R7 slow null plus gap", t1, 360);
        check(g2 === framed(b, 1'b0), "R7 slow word content", g2, framed(b, 1'b0));
        slow_sel = 1'b0;
    endtask

    task automatic t_second_only;
        int act = 0;
        @(negedge clk); bus_data = 16'hBEEF; ld_hi = 1'b1;
        @(negedge clk); ld_hi = 1'b0; tx_en = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (line_hi || line_lo || !ready) act++;
        end
        tx_en = 1'b0;
        check(act == 0, "R1 lone second strobe ignored", act, 0);
    endtask

    task automatic t_overfill;
        logic [31:0] got; bit ok; int tail, bad = 0;
        for (int i = 0; i < 9; i++) load_word(31'(32'h0101_0101 * (i + 1)));
        check(ready === 1'b0, "R3 ready low with queue", ready, 0);
        tx_en = 1'b1;
        for (int i = 0; i < 8; i++) begin
            recv(5, got, ok, tail);
            if (got !== framed(31'(32'h0101_0101 * (i + 1)), 1'b0)) bad++;
        end
        tx_en = 1'b0;
        check(bad == 0, "R2 first eight words kept", bad, 0);
        check(tail == CAP, "R2 ninth word dropped", tail, CAP);
        check(ready === 1'b1, "R3 ready after full drain", ready, 1);
    endtask

    task automatic t_enable_drop;
        logic [30:0] a = 31'h3C3C_1234, b = 31'h4321_6789;
        logic [31:0] g1, g2; bit ok1, ok2; int t1, t2;
        load_word(a); load_word(b);
        tx_en = 1'b1;
        fork
            recv(5, g1, ok1, t1);
            begin repeat (60) @(negedge clk); tx_en = 1'b0; end
        join
        check(ok1 && g1 === framed(a, 1'b0), "R9 current word completes", g1, framed(a, 1'b0));
        check(t1 == CAP, "R9 no new word without enable", t1, CAP);
        check(ready === 1'b0, "R9 R3 ready low with word left", ready, 0);
        tx_en = 1'b1;
        recv(5, g2, ok2, t2);
        tx_en = 1'b0;
        check(g2 === framed(b, 1'b0), "R9 held word sent on re-enable", g2, framed(b, 1'b0));
    endtask

    task automatic t_selftest;
        logic [31:0] got; bit ok; int tail, bad = 0, leak = 0;
        st_en = 1'b1;
        load_word(31'h6B2D_19E4);
        tx_en = 1'b1;
        fork
            recv(5, got, ok, tail);
            for (int i = 0; i < 330; i++) begin
                @(negedge clk);
                if (loop1_hi !== line_hi || loop1_lo !== line_lo ||
                    loop2_hi !== line_lo || loop2_lo !== line_hi) bad++;
            end
        join
        check(bad == 0, "R10 loopback true and complemented", bad, 0);
        st_en = 1'b0;
        load_word(31'h1111_2222);
        fork
            recv(5, got, ok, tail);
            for (int i = 0; i < 330; i++) begin
                @(negedge clk);
                if (loop1_hi || loop1_lo || loop2_hi || loop2_lo) leak++;
            end
        join
        tx_en = 1'b0;
        check(leak == 0, "R10 loopback quiet when disabled", leak, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_fast();
        t_even_parity();
        t_two_fast();
        t_two_slow();
        t_second_only();
        t_overfill();
        t_enable_drop();
        t_selftest();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule